// File: doc/BRIEF.md
# CF-ATA Task File Address Remapper

This block sits between a card-side bus and an ATA-style task-file core. Every 16-bit access arrives with a raw address, and the block turns that address into a task-file offset. One of four address maps is in force at a time, chosen by a two-bit mode input: a memory window that aliases onto the data port, a contiguous I/O map, and the primary or secondary legacy I/O maps. In the two legacy maps the high control port pair folds onto offsets 0xE and 0xF.

Once the offset is known, the access goes to one of several places. These are the core's data port, the core's error/feature register, the local alternate-status / device-control register, a synthesized drive-address register, a one-byte side latch, or the core's generic register port. The block keeps the device-control register and derives the interrupt line and a card soft-reset pulse from it. It also keeps a power-down flag, which is set from outside and cleared by the first generic write to the core. When that happens the block raises a ready indication.

Top module: `cfTaskFileMapper`

## Requirements
- R1: With addrMode = 0 (memory window), any raw address from 0x400 to 0x7FF is treated as offset 0 (data port). Any other raw address is used as is.
- R2: With addrMode = 1 (contiguous I/O), only raw address bits [3:0] form the offset and the upper bits are discarded.
- R3: With addrMode = 2 (primary), raw 0x1F0..0x1FF becomes 0x0..0xF and raw 0x3F0..0x3FF has 0x3E8 subtracted, so 0x3F6 becomes 0xE and 0x3F8 becomes 0x10. Any other raw address is left unchanged.
- R4: With addrMode = 3 (secondary), raw 0x170..0x17F has 0x170 subtracted and raw 0x370..0x37F has 0x368 subtracted. Any other raw address is left unchanged.
- R5: Offsets 0x0 and 0x8 access core register 0 (coreAddr = 0) as a 16-bit data word. A read returns coreRdata and also stores that word in the side latch.
- R6: Offset 0xD reads and writes core register 1 (coreAddr = 1). Such a write does not clear power-down.
- R7: A read of offset 0xE returns {8'h00, coreStatus} when drivePresent is 1, and 0 otherwise. It raises no core strobe.
- R8: A read of offset 0xF returns 0xC2 ORed with the inverted driveHeadSel[3:0] placed at bits [5:2], and raises no core strobe. A write to 0xF goes to the generic port.
- R9: A write to offset 0xE loads devCtrl from reqWdata[7:0] with no core strobe. If bit 2 (soft reset) is set, cardResetPulse is 1 for the next cycle, and devCtrl, the side latch, byteCycle and pwrDown (unless pdSet) are cleared.
- R10: irqOut equals coreIrq AND NOT devCtrl[1] (interrupt disable) AND NOT devCtrl[2].
- R11: A write that takes the generic port while pwrDown is 1 clears pwrDown, sets readyPin and is still forwarded to the core. Data-port and offset 0xD writes leave pwrDown alone. pdSet has priority over the clear, and readyClr clears readyPin.
- R12: A read of offset 0x9 returns {8'h00, latch[15:8]} with no core strobe. A write to 0x9 loads the latch with {8'h00, reqWdata[7:0]} and toggles byteCycle.
- R13: A read request gives rspValid = 1 and rspRdata on the cycle after the request. A write gives no response. Translated addresses at or above 0x10, and offsets with no local meaning, go to the generic port with coreAddr equal to the translated address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrMode | input | 2 | Address map select (0 window, 1 contiguous, 2 primary, 3 secondary) |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Raw access address |
| reqWdata | input | 16 | Write data |
| rspValid | output | 1 | Read response valid (one cycle after a read request) |
| rspRdata | output | 16 | Read response data |
| coreRd | output | 1 | Core register read strobe |
| coreWr | output | 1 | Core register write strobe |
| coreAddr | output | 12 | Core register address (translated) |
| coreWdata | output | 16 | Core write data |
| coreRdata | input | 16 | Core read data, valid in the strobe cycle |
| coreStatus | input | 8 | Core status byte for alternate status |
| drivePresent | input | 1 | A drive is attached to the core |
| driveHeadSel | input | 4 | Core select register bits [3:0] |
| coreIrq | input | 1 | Interrupt request from the core |
| pdSet | input | 1 | Set the power-down flag |
| readyClr | input | 1 | Clear the ready indication |
| devCtrl | output | 8 | Device-control register |
| cardResetPulse | output | 1 | One-cycle card soft-reset request |
| irqOut | output | 1 | Interrupt line to the card bus |
| pwrDown | output | 1 | Power-down flag |
| readyPin | output | 1 | Ready indication raised on wake-up |
| byteCycle | output | 1 | Byte-cycle flag toggled by offset 0x9 writes |

## Verification
The hardest case to reach from the ports is a collision in the power-down logic. pdSet arrives in the same cycle as a waking generic write, and both the priority rule and the ready indication must still hold. The stimulus first parks the block in power-down, then issues non-waking writes to the data port and offset 0xD, and only then fires the waking write, both alone and together with pdSet. The side latch high byte can only be seen after a data-port read has filled it, so a read of offset 0x9 is placed directly after a data read in the vector table.

// File: rtl/cfMapPkg.sv
package cfMapPkg;

  typedef enum logic [1:0] {
    MODE_MEMWIN    = 2'd0,
    MODE_CONTIG    = 2'd1,
    MODE_PRIMARY   = 2'd2,
    MODE_SECONDARY = 2'd3
  } addrMode_t;

  typedef enum logic [1:0] {
    RS_CORE   = 2'd0,
    RS_STATUS = 2'd1,
    RS_DADDR  = 2'd2,
    RS_HIBYTE = 2'd3
  } rspSel_t;

  // strobes from the decoder to the register datapath
  typedef struct packed {
    logic    rspLoad;
    rspSel_t rspSel;
    logic    ctrlLoad;
    logic    wake;
    logic    latchWord;
    logic    latchLow;
  } pathStb_t;

  localparam int unsigned TF_W      = 4;
  localparam int unsigned OFF_DATA0 = 4'h0;
  localparam int unsigned OFF_DATA1 = 4'h8;
  localparam int unsigned OFF_HIBYT = 4'h9;
  localparam int unsigned OFF_ERRFT = 4'hD;
  localparam int unsigned OFF_ALTCT = 4'hE;
  localparam int unsigned OFF_DADDR = 4'hF;
  localparam int unsigned CORE_DATA = 0;
  localparam int unsigned CORE_ERR  = 1;

endpackage

// File: rtl/cfAddrDecode.sv
module cfAddrDecode
  import cfMapPkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned WIN_BASE = 'h400,
  parameter int unsigned WIN_SIZE = 'h400,
  parameter int unsigned PRI_TF   = 'h1F0,
  parameter int unsigned PRI_CTL  = 'h3F0,
  parameter int unsigned SEC_TF   = 'h170,
  parameter int unsigned SEC_CTL  = 'h370,
  parameter int unsigned CTL_FOLD = 'h8
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        addrMode,
  output pathStb_t          stb,
  output logic              coreRd,
  output logic              coreWr,
  output logic [ADDR_W-1:0] coreAddr
);

  localparam logic [ADDR_W-1:0] WIN_LO  = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] WIN_HI  = ADDR_W'(WIN_BASE + WIN_SIZE - 1);
  localparam int unsigned       HI_W    = ADDR_W - TF_W;
  localparam logic [HI_W-1:0]   PRI_TFH = HI_W'(PRI_TF >> TF_W);
  localparam logic [HI_W-1:0]   PRI_CTH = HI_W'(PRI_CTL >> TF_W);
  localparam logic [HI_W-1:0]   SEC_TFH = HI_W'(SEC_TF >> TF_W);
  localparam logic [HI_W-1:0]   SEC_CTH = HI_W'(SEC_CTL >> TF_W);

  logic [ADDR_W-1:0] xlat;
  logic [TF_W-1:0]   off;
  logic              isLocal;

  // fold one legacy window pair (task file + control block)
  function automatic logic [ADDR_W-1:0] legacyFold(
    input logic [ADDR_W-1:0] a,
    input logic [HI_W-1:0]   tfHi,
    input logic [HI_W-1:0]   ctHi,
    input int unsigned       tfBase,
    input int unsigned       ctBase
  );
    logic [ADDR_W-1:0] r;
    r = a;
    if (a[ADDR_W-1:TF_W] == ctHi)
      r = a - ADDR_W'(ctBase) + ADDR_W'(CTL_FOLD);
    else if (a[ADDR_W-1:TF_W] == tfHi)
      r = a - ADDR_W'(tfBase);
    return r;
  endfunction

  always_comb begin
    xlat = reqAddr;
    case (addrMode_t'(addrMode))
      MODE_MEMWIN:    if (reqAddr >= WIN_LO && reqAddr <= WIN_HI) xlat = '0;
      MODE_CONTIG:    xlat = {{HI_W{1'b0}}, reqAddr[TF_W-1:0]};
      MODE_PRIMARY:   xlat = legacyFold(reqAddr, PRI_TFH, PRI_CTH, PRI_TF, PRI_CTL);
      MODE_SECONDARY: xlat = legacyFold(reqAddr, SEC_TFH, SEC_CTH, SEC_TF, SEC_CTL);
      default:        xlat = reqAddr;
    endcase
  end

  assign off     = xlat[TF_W-1:0];
  assign isLocal = (xlat[ADDR_W-1:TF_W] == '0);

  always_comb begin
    stb      = '0;
    coreRd   = 1'b0;
    coreWr   = 1'b0;
    coreAddr = xlat;
    if (reqValid) begin
      stb.rspLoad = !reqWrite;
      stb.rspSel  = RS_CORE;
      if (isLocal && (off == TF_W'(OFF_DATA0) || off == TF_W'(OFF_DATA1))) begin
        coreAddr      = ADDR_W'(CORE_DATA);
        coreRd        = !reqWrite;
        coreWr        = reqWrite;
        stb.latchWord = !reqWrite;
      end else if (isLocal && off == TF_W'(OFF_HIBYT)) begin
        stb.latchLow = reqWrite;
        stb.rspSel   = RS_HIBYTE;
      end else if (isLocal && off == TF_W'(OFF_ERRFT)) begin
        coreAddr = ADDR_W'(CORE_ERR);
        coreRd   = !reqWrite;
        coreWr   = reqWrite;
      end else if (isLocal && off == TF_W'(OFF_ALTCT)) begin
        stb.ctrlLoad = reqWrite;
        stb.rspSel   = RS_STATUS;
      end else if (isLocal && off == TF_W'(OFF_DADDR) && !reqWrite) begin
        stb.rspSel = RS_DADDR;
      end else begin
        // generic pass-through, including unmapped addresses
        coreRd   = !reqWrite;
        coreWr   = reqWrite;
        stb.wake = reqWrite;
      end
    end
  end

endmodule

// File: rtl/cfRegPath.sv
module cfRegPath
  import cfMapPkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CTRL_W   = 8,
  parameter int unsigned IEN_BIT  = 1,
  parameter int unsigned SRST_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStb_t          stb,
  input  logic [CTRL_W-1:0] ctrlData,
  input  logic [7:0]        lowByte,
  input  logic [DATA_W-1:0] coreRdata,
  input  logic [7:0]        coreStatus,
  input  logic              drivePresent,
  input  logic [3:0]        driveHeadSel,
  input  logic              coreIrq,
  input  logic              pdSet,
  input  logic              readyClr,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [CTRL_W-1:0] devCtrl,
  output logic              cardResetPulse,
  output logic              irqOut,
  output logic              pwrDown,
  output logic              readyPin,
  output logic              byteCycle
);

  localparam logic [7:0] DADDR_FIXED = 8'hC2;

  logic [DATA_W-1:0] latchWord;
  logic [DATA_W-1:0] rspMux;
  logic              softRst;
  logic              wakeHit;

  assign softRst = stb.ctrlLoad && ctrlData[SRST_BIT];
  assign wakeHit = stb.wake && pwrDown;

  always_comb begin
    case (stb.rspSel)
      RS_STATUS: rspMux = drivePresent ? DATA_W'(coreStatus) : '0;
      RS_DADDR:  rspMux = DATA_W'(DADDR_FIXED | {2'b00, ~driveHeadSel, 2'b00});
      RS_HIBYTE: rspMux = DATA_W'(latchWord[DATA_W-1:DATA_W-8]);
      default:   rspMux = coreRdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid       <= 1'b0;
      rspRdata       <= '0;
      devCtrl        <= '0;
      cardResetPulse <= 1'b0;
      pwrDown        <= 1'b0;
      readyPin       <= 1'b0;
      byteCycle      <= 1'b0;
      latchWord      <= '0;
    end else begin
      rspValid       <= stb.rspLoad;
      cardResetPulse <= softRst;
      if (stb.rspLoad) rspRdata <= rspMux;

      if (softRst) begin
        devCtrl   <= '0;
        latchWord <= '0;
        byteCycle <= 1'b0;
        pwrDown   <= pdSet;
      end else begin
        if (stb.ctrlLoad) devCtrl <= ctrlData;
        if (stb.latchWord) latchWord <= coreRdata;
        else if (stb.latchLow) latchWord <= DATA_W'(lowByte);
        if (stb.latchLow) byteCycle <= !byteCycle;
        if (pdSet) pwrDown <= 1'b1;
        else if (wakeHit) pwrDown <= 1'b0;
      end

      if (wakeHit) readyPin <= 1'b1;
      else if (readyClr) readyPin <= 1'b0;
    end
  end

  assign irqOut = coreIrq && !devCtrl[IEN_BIT] && !devCtrl[SRST_BIT];

endmodule

// File: rtl/cfTaskFileMapper.sv
module cfTaskFileMapper
  import cfMapPkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        addrMode,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              coreRd,
  output logic              coreWr,
  output logic [ADDR_W-1:0] coreAddr,
  output logic [DATA_W-1:0] coreWdata,
  input  logic [DATA_W-1:0] coreRdata,
  input  logic [7:0]        coreStatus,
  input  logic              drivePresent,
  input  logic [3:0]        driveHeadSel,
  input  logic              coreIrq,
  input  logic              pdSet,
  input  logic              readyClr,
  output logic [CTRL_W-1:0] devCtrl,
  output logic              cardResetPulse,
  output logic              irqOut,
  output logic              pwrDown,
  output logic              readyPin,
  output logic              byteCycle
);

  pathStb_t stb;

  cfAddrDecode #(.ADDR_W(ADDR_W)) uDecode (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .addrMode (addrMode),
    .stb      (stb),
    .coreRd   (coreRd),
    .coreWr   (coreWr),
    .coreAddr (coreAddr)
  );

  cfRegPath #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) uPath (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .ctrlData       (reqWdata[CTRL_W-1:0]),
    .lowByte        (reqWdata[7:0]),
    .coreRdata      (coreRdata),
    .coreStatus     (coreStatus),
    .drivePresent   (drivePresent),
    .driveHeadSel   (driveHeadSel),
    .coreIrq        (coreIrq),
    .pdSet          (pdSet),
    .readyClr       (readyClr),
    .rspValid       (rspValid),
    .rspRdata       (rspRdata),
    .devCtrl        (devCtrl),
    .cardResetPulse (cardResetPulse),
    .irqOut         (irqOut),
    .pwrDown        (pwrDown),
    .readyPin       (readyPin),
    .byteCycle      (byteCycle)
  );

  assign coreWdata = reqWdata;

endmodule

// File: rtl/cfTaskFileMapperChk.sv
module cfTaskFileMapperChk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CTRL_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        addrMode,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic              coreRd,
  input logic              coreWr,
  input logic              coreIrq,
  input logic [CTRL_W-1:0] devCtrl,
  input logic              cardResetPulse,
  input logic              irqOut,
  input logic              byteCycle
);

  // R13: every read gets a response on the next cycle
  a_r13_read_resp: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite |=> rspValid);

  // R13: writes produce no response
  a_r13_write_no_resp: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqWrite |=> !rspValid);

  // R5: never read and write the core together
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(coreRd && coreWr));

  // R9: soft reset leaves the control register cleared
  a_r9_reset_clears_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    cardResetPulse |-> devCtrl == '0);

  // R10: interrupt disable bit masks the line
  a_r10_irq_mask: assert property (@(posedge clk) disable iff (!rstN)
    devCtrl[1] |-> !irqOut);

  // R10: unmasked request reaches the line
  a_r10_irq_pass: assert property (@(posedge clk) disable iff (!rstN)
    coreIrq && devCtrl[2:1] == 2'b00 |-> irqOut);

  // R12: write to the odd byte offset toggles the cycle flag
  a_r12_cycle_toggle: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqWrite && addrMode == 2'd1 && reqAddr[3:0] == 4'h9
    |=> byteCycle != $past(byteCycle));

  // R7: alternate status read does not touch the core
  a_r7_alt_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite && addrMode == 2'd1 && reqAddr[3:0] == 4'hE |-> !coreRd);

endmodule

bind cfTaskFileMapper cfTaskFileMapperChk #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) uChk (
  .clk            (clk),
  .rstN           (rstN),
  .addrMode       (addrMode),
  .reqValid       (reqValid),
  .reqWrite       (reqWrite),
  .reqAddr        (reqAddr),
  .rspValid       (rspValid),
  .coreRd         (coreRd),
  .coreWr         (coreWr),
  .coreIrq        (coreIrq),
  .devCtrl        (devCtrl),
  .cardResetPulse (cardResetPulse),
  .irqOut         (irqOut),
  .byteCycle      (byteCycle)
);

// File: tb/cfTaskFileMapper_test.sv
`timescale 1ns/1ps
module cfTaskFileMapper_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  addrMode = 2'd0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        rspValid;
  logic [15:0] rspRdata;
  logic        coreRd, coreWr;
  logic [11:0] coreAddr;
  logic [15:0] coreWdata, coreRdata;
  logic [7:0]  coreStatus = 8'h51;
  logic        drivePresent = 1'b1;
  logic [3:0]  driveHeadSel = 4'h5;
  logic        coreIrq = 1'b0, pdSet = 1'b0, readyClr = 1'b0;
  logic [7:0]  devCtrl;
  logic        cardResetPulse, irqOut, pwrDown, readyPin, byteCycle;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  // core model: read data derived from address
  assign coreRdata = 16'hA000 ^ {4'h0, coreAddr};

  cfTaskFileMapper uut (.*);

  typedef struct packed {
    logic [1:0]  mode;
    logic        wr;
    logic [11:0] addr;
    logic        expRd;
    logic        expWr;
    logic [11:0] expCA;
    logic [15:0] expRsp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 1'b0, 12'h400, 1'b1, 1'b0, 12'h000, 16'hA000},
    '{2'd0, 1'b0, 12'h7FE, 1'b1, 1'b0, 12'h000, 16'hA000},
    '{2'd0, 1'b0, 12'h003, 1'b1, 1'b0, 12'h003, 16'hA003},
    '{2'd0, 1'b0, 12'h800, 1'b1, 1'b0, 12'h800, 16'hA800},
    '{2'd1, 1'b0, 12'h5F3, 1'b1, 1'b0, 12'h003, 16'hA003},
    '{2'd1, 1'b0, 12'h00D, 1'b1, 1'b0, 12'h001, 16'hA001},
    '{2'd2, 1'b0, 12'h1F7, 1'b1, 1'b0, 12'h007, 16'hA007},
    '{2'd2, 1'b0, 12'h3F6, 1'b0, 1'b0, 12'h000, 16'h0051},
    '{2'd2, 1'b0, 12'h3F7, 1'b0, 1'b0, 12'h000, 16'h00EA},
    '{2'd3, 1'b0, 12'h172, 1'b1, 1'b0, 12'h002, 16'hA002},
    '{2'd3, 1'b0, 12'h376, 1'b0, 1'b0, 12'h000, 16'h0051},
    '{2'd3, 1'b0, 12'h1F2, 1'b1, 1'b0, 12'h1F2, 16'hA1F2},
    '{2'd2, 1'b0, 12'h3F8, 1'b1, 1'b0, 12'h010, 16'hA010},
    '{2'd1, 1'b1, 12'h008, 1'b0, 1'b1, 12'h000, 16'h0000},
    '{2'd1, 1'b0, 12'h008, 1'b1, 1'b0, 12'h000, 16'hA000},
    '{2'd1, 1'b0, 12'h009, 1'b0, 1'b0, 12'h000, 16'h00A0}
  };

  logic        sRd, sWr, sRspV, sPulse;
  logic [11:0] sAddr;
  logic [15:0] sWdata, sRsp;

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doAccess(input logic [1:0] m, input logic w, input logic [11:0] a,
                          input logic [15:0] d);
    @(negedge clk);
    addrMode = m; reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    #2;
    sRd = coreRd; sWr = coreWr; sAddr = coreAddr; sWdata = coreWdata;
    @(negedge clk);
    sRspV = rspValid; sRsp = rspRdata; sPulse = cardResetPulse;
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check(rspValid == 0 && devCtrl == 0, "R13 reset rsp/ctrl", {rspValid, devCtrl}, 0);
    check(pwrDown == 0 && readyPin == 0 && byteCycle == 0 && cardResetPulse == 0,
          "R11 reset flags", {pwrDown, readyPin, byteCycle, cardResetPulse}, 0);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R12 R13
    for (int i = 0; i < NV; i++) begin
      doAccess(TBL[i].mode, TBL[i].wr, TBL[i].addr, 16'h1234);
      check(sRd == TBL[i].expRd && sWr == TBL[i].expWr, $sformatf("R13 strobes row %0d", i),
            {sRd, sWr}, {TBL[i].expRd, TBL[i].expWr});
      if (TBL[i].expRd || TBL[i].expWr)
        check(sAddr == TBL[i].expCA, $sformatf("R1 R2 R3 R4 coreAddr row %0d", i),
              sAddr, TBL[i].expCA);
      if (TBL[i].wr) begin
        check(sWdata == 16'h1234, "R5 write data", sWdata, 16'h1234);
        check(!sRspV, "R13 no write response", sRspV, 0);
      end else
        check(sRspV && sRsp == TBL[i].expRsp, $sformatf("R13 response row %0d", i),
              {sRspV, sRsp}, {1'b1, TBL[i].expRsp});
    end

    // R7 no drive present
    drivePresent = 1'b0;
    doAccess(2'd1, 1'b0, 12'h00E, 16'h0);
    check(sRsp == 16'h0 && !sRd, "R7 absent drive", sRsp, 0);
    drivePresent = 1'b1;

    // R8 write to 0xF goes generic
    doAccess(2'd1, 1'b1, 12'h00F, 16'h0077);
    check(sWr && sAddr == 12'h00F, "R8 write F generic", {sWr, sAddr}, {1'b1, 12'h00F});

    // R10 interrupt masking
    coreIrq = 1'b1;
    #1 check(irqOut == 1'b1, "R10 irq passes", irqOut, 1);
    doAccess(2'd1, 1'b1, 12'h00E, 16'h0002);
    check(!sWr && devCtrl == 8'h02, "R9 ctrl load", {sWr, devCtrl}, 8'h02);
    check(irqOut == 1'b0, "R10 irq masked", irqOut, 0);
    doAccess(2'd1, 1'b1, 12'h00E, 16'h0000);
    check(irqOut == 1'b1, "R10 irq unmasked", irqOut, 1);
    coreIrq = 1'b0;

    // R12 byte latch write
    doAccess(2'd1, 1'b1, 12'h009, 16'h55C3);
    check(byteCycle == 1'b1 && !sWr, "R12 toggle", byteCycle, 1);
    doAccess(2'd1, 1'b0, 12'h009, 16'h0);
    check(sRsp == 16'h0000 && !sRd, "R12 high byte after low write", sRsp, 0);

    // R11 power-down handling
    @(negedge clk) pdSet = 1'b1;
    @(negedge clk) pdSet = 1'b0;
    check(pwrDown == 1'b1, "R11 pd set", pwrDown, 1);
    doAccess(2'd1, 1'b1, 12'h00D, 16'h0011);
    check(pwrDown == 1'b1 && sWr && sAddr == 12'h001, "R6 feature write keeps pd",
          {pwrDown, sAddr}, {1'b1, 12'h001});
    doAccess(2'd1, 1'b1, 12'h000, 16'h0022);
    check(pwrDown == 1'b1 && readyPin == 1'b0, "R11 data write keeps pd",
          {pwrDown, readyPin}, 2'b10);
    doAccess(2'd1, 1'b1, 12'h003, 16'h0033);
    check(sWr && sAddr == 12'h003, "R11 wake write forwarded", sAddr, 12'h003);
    check(pwrDown == 1'b0 && readyPin == 1'b1, "R11 wake", {pwrDown, readyPin}, 2'b01);
    @(negedge clk) readyClr = 1'b1;
    @(negedge clk) readyClr = 1'b0;
    check(readyPin == 1'b0, "R11 ready clear", readyPin, 0);

    // R11 set priority over wake
    @(negedge clk) pdSet = 1'b1;
    @(negedge clk);
    addrMode = 2'd1; reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 12'h004;
    @(negedge clk);
    pdSet = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    check(pwrDown == 1'b1 && readyPin == 1'b1, "R11 set wins", {pwrDown, readyPin}, 2'b11);

    // R9 soft reset clears state
    doAccess(2'd1, 1'b1, 12'h009, 16'h0001);
    check(byteCycle == 1'b0, "R12 toggle back", byteCycle, 0);
    doAccess(2'd1, 1'b1, 12'h009, 16'h0001);
    doAccess(2'd1, 1'b1, 12'h00E, 16'h0006);
    check(sPulse == 1'b1, "R9 reset pulse", sPulse, 1);
    check(devCtrl == 8'h00 && byteCycle == 1'b0 && pwrDown == 1'b0,
          "R9 state cleared", {devCtrl, byteCycle, pwrDown}, 0);
    @(negedge clk);
    check(cardResetPulse == 1'b0, "R9 pulse one cycle", cardResetPulse, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule